// File: doc/BRIEF.md
# Paged Instruction Address Sequencer with Return Stack

This block produces the 14-bit fetch address for a program store of 16K words. The store is divided into sixteen pages of 1K words, and page n spans addresses n*0x400 through n*0x400+0x3FF. The address register advances by one on each enabled cycle. It can also be redirected by one of six command strobes that the instruction decoder drives: jump, call, return, accumulator-move, accumulator-add and table-lookup. Each redirecting command treats the upper address bits in its own way. Some take the page number from a 4-bit page-select field held in a status register. Some clear address bits 9 and 8. Table lookup leaves every bit above the low byte as it was.

Subroutine linkage uses an 8-entry circular return stack. A call saves the address after the current one and then branches. A return restores the most recently saved address. When more than eight calls nest, the oldest saved entry is overwritten. Popping an empty stack wraps the pointer without any error indication. The decoder guarantees that at most one command strobe is high in any cycle.

Top module: `paged_pc_seq`

## Requirements
- R1: After reset the address output is 0x0000, every stack slot holds 0x0000 and the stack pointer is at slot 0.
- R2: With no command strobe high and `inc_en` high, the address rises by 1 per clock and wraps from 0x3FFF to 0x0000. Any command strobe takes precedence over `inc_en`.
- R3: With no command strobe high and `inc_en` low, the address holds its value.
- R4: A jump loads `imm_target` into address bits 9..0 and `page_sel` into bits 13..10.
- R5: A call stores the current address plus one (modulo 2^14) on the stack, then loads bits 13..10 from `page_sel` and bits 9..0 from `imm_target`.
- R6: A return loads the address from the most recently stored stack entry and removes that entry.
- R7: An accumulator-move loads `acc_val` into bits 7..0, clears bits 9..8 and loads `page_sel` into bits 13..10.
- R8: An accumulator-add sets bits 7..0 to (current bits 7..0 + `acc_val`) mod 256 and discards the carry. It clears bits 9..8 and loads `page_sel` into bits 13..10.
- R9: A table lookup sets bits 7..0 as in R8 but keeps bits 13..8 unchanged. `page_sel` has no effect on it.
- R10: Eight nested calls followed by eight returns restore the saved addresses in reverse order of storing.
- R11: A ninth call without an intervening return overwrites the oldest entry. After nine calls, nine returns give saved addresses 9, 8, ..., 2 and then 9 again.
- R12: A return on an empty stack after reset loads 0x0000 from the wrapped slot. A later call and return still pair correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_en | input | 1 | Sequential advance enable |
| jump_stb | input | 1 | Jump command strobe |
| call_stb | input | 1 | Call command strobe |
| ret_stb | input | 1 | Return command strobe |
| movpc_stb | input | 1 | Accumulator-move command strobe |
| addpc_stb | input | 1 | Accumulator-add command strobe |
| tbl_stb | input | 1 | Table-lookup command strobe |
| imm_target | input | 10 | In-page branch target |
| acc_val | input | 8 | Accumulator value |
| page_sel | input | 4 | Page-select field from the status register |
| pc_o | output | 14 | Current instruction address |

## Verification
Sequential advance and a command redirect can be requested in the same cycle. The bench raises `inc_en` together with a jump, a call and a table lookup, and it expects the command result with no extra +1. A store and a retrieve on the stack also fall in adjacent cycles. A call followed at once by a return must give back exactly the address after the call site. The nine-deep overflow and the empty pop are judged by the addresses that later returns deliver.

// File: rtl/pcstk_pkg.sv
package pcstk_pkg;

  // Kind of address update chosen for a cycle
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_SEQ  = 3'd1,
    OP_JMP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_MOV  = 3'd5,
    OP_ADD  = 3'd6,
    OP_TBL  = 3'd7
  } pc_op_e;

  typedef struct packed {
    logic jump;
    logic call;
    logic ret;
    logic mov;
    logic add;
    logic tbl;
  } cmd_t;

  // Strobes are one-hot by contract; a fixed order keeps the choice
  // deterministic should that contract ever be broken.
  function automatic pc_op_e pick_op(cmd_t c, logic inc);
    pc_op_e op;
    if (c.ret)       op = OP_RET;
    else if (c.call) op = OP_CALL;
    else if (c.jump) op = OP_JMP;
    else if (c.mov)  op = OP_MOV;
    else if (c.add)  op = OP_ADD;
    else if (c.tbl)  op = OP_TBL;
    else if (inc)    op = OP_SEQ;
    else             op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/pcstk_decode.sv
module pcstk_decode
  import pcstk_pkg::*;
(
  input  cmd_t   cmd_i,
  input  logic   inc_i,
  output pc_op_e op_o,
  output logic   push_o,
  output logic   pop_o,
  output logic   redirect_o,
  output logic   seq_o,
  output logic   hold_o
);

  always_comb begin
    op_o       = pick_op(cmd_i, inc_i);
    push_o     = (op_o == OP_CALL);
    pop_o      = (op_o == OP_RET);
    seq_o      = (op_o == OP_SEQ);
    hold_o     = (op_o == OP_HOLD);
    redirect_o = !(seq_o || hold_o);
  end

endmodule

// File: rtl/pcstk_stack.sv
module pcstk_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_up;
  logic [PTR_W-1:0] ptr_dn;
  logic [W-1:0]     slot_w [DEPTH];

  // Circular pointer: the next free slot; wraps in both directions
  always_comb begin
    ptr_up = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    ptr_dn = (ptr_q == '0) ? LAST : ptr_q - PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (push_i) begin
      ptr_q <= ptr_up;
    end else if (pop_i) begin
      ptr_q <= ptr_dn;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q;
    logic         wr;
    assign wr = push_i && (ptr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr) begin
        q <= din_i;
      end
    end
    assign slot_w[g] = q;
  end

  // Most recent entry sits just below the free slot
  assign top_o = slot_w[ptr_dn];

endmodule

// File: rtl/pcstk_next.sv
module pcstk_next
  import pcstk_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int LOW_W  = 8
) (
  input  pc_op_e                     op_i,
  input  logic [PAGE_W+OFS_W-1:0]    pc_i,
  input  logic [PAGE_W-1:0]          page_i,
  input  logic [OFS_W-1:0]           imm_i,
  input  logic [LOW_W-1:0]           acc_i,
  input  logic [PAGE_W+OFS_W-1:0]    top_i,
  output logic [PAGE_W+OFS_W-1:0]    pc_o,
  output logic [PAGE_W+OFS_W-1:0]    link_o
);

  localparam int PC_W  = PAGE_W + OFS_W;
  localparam int MID_W = OFS_W - LOW_W;
  localparam int UP_W  = PC_W - LOW_W;

  typedef logic [PC_W-1:0] addr_t;

  function automatic addr_t step_one(addr_t a);
    return a + PC_W'(1);
  endfunction

  function automatic addr_t paged_target(logic [PAGE_W-1:0] pg,
                                         logic [OFS_W-1:0] ofs);
    return {pg, ofs};
  endfunction

  function automatic logic [LOW_W-1:0] low_sum(addr_t a,
                                               logic [LOW_W-1:0] v);
    return a[LOW_W-1:0] + v;
  endfunction

  // Page reloaded, middle bits cleared, low byte supplied
  function automatic addr_t cleared_mid(logic [PAGE_W-1:0] pg,
                                        logic [LOW_W-1:0] lo);
    return {pg, {MID_W{1'b0}}, lo};
  endfunction

  // Everything above the low byte retained
  function automatic addr_t kept_upper(addr_t a, logic [LOW_W-1:0] lo);
    logic [UP_W-1:0] up;
    up = a[PC_W-1:LOW_W];
    return {up, lo};
  endfunction

  always_comb begin
    link_o = step_one(pc_i);
    unique case (op_i)
      OP_SEQ:  pc_o = step_one(pc_i);
      OP_JMP:  pc_o = paged_target(page_i, imm_i);
      OP_CALL: pc_o = paged_target(page_i, imm_i);
      OP_RET:  pc_o = top_i;
      OP_MOV:  pc_o = cleared_mid(page_i, acc_i);
      OP_ADD:  pc_o = cleared_mid(page_i, low_sum(pc_i, acc_i));
      OP_TBL:  pc_o = kept_upper(pc_i, low_sum(pc_i, acc_i));
      default: pc_o = pc_i;
    endcase
  end

endmodule

// File: rtl/paged_pc_seq.sv
module paged_pc_seq
  import pcstk_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int LOW_W  = 8,
  parameter int DEPTH  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inc_en,
  input  logic                      jump_stb,
  input  logic                      call_stb,
  input  logic                      ret_stb,
  input  logic                      movpc_stb,
  input  logic                      addpc_stb,
  input  logic                      tbl_stb,
  input  logic [OFS_W-1:0]          imm_target,
  input  logic [LOW_W-1:0]          acc_val,
  input  logic [PAGE_W-1:0]         page_sel,
  output logic [PAGE_W+OFS_W-1:0]   pc_o
);

  localparam int PC_W = PAGE_W + OFS_W;

  cmd_t            cmd;
  pc_op_e          op;
  logic            push_ev;
  logic            pop_ev;
  logic            redirect_ev;
  logic            seq_ev;
  logic            hold_ev;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] link_addr;
  logic [PC_W-1:0] stack_top;

  assign cmd = '{jump: jump_stb, call: call_stb, ret: ret_stb,
                 mov: movpc_stb, add: addpc_stb, tbl: tbl_stb};

  pcstk_decode u_dec (
    .cmd_i      (cmd),
    .inc_i      (inc_en),
    .op_o       (op),
    .push_o     (push_ev),
    .pop_o      (pop_ev),
    .redirect_o (redirect_ev),
    .seq_o      (seq_ev),
    .hold_o     (hold_ev)
  );

  pcstk_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stk (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (push_ev),
    .pop_i  (pop_ev),
    .din_i  (link_addr),
    .top_o  (stack_top)
  );

  pcstk_next #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .LOW_W(LOW_W)) u_nxt (
    .op_i   (op),
    .pc_i   (pc_q),
    .page_i (page_sel),
    .imm_i  (imm_target),
    .acc_i  (acc_val),
    .top_i  (stack_top),
    .pc_o   (pc_d),
    .link_o (link_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/paged_pc_seq_chk.sv
module paged_pc_seq_chk #(
  parameter int PAGE_W = 4,
  parameter int OFS_W  = 10,
  parameter int LOW_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    inc_en,
  input logic                    jump_stb,
  input logic                    call_stb,
  input logic                    ret_stb,
  input logic                    movpc_stb,
  input logic                    addpc_stb,
  input logic                    tbl_stb,
  input logic [OFS_W-1:0]        imm_target,
  input logic [LOW_W-1:0]        acc_val,
  input logic [PAGE_W-1:0]       page_sel,
  input logic [PAGE_W+OFS_W-1:0] pc_o,
  input logic                    push_ev,
  input logic                    pop_ev,
  input logic                    seq_ev,
  input logic                    hold_ev
);

  localparam int PC_W  = PAGE_W + OFS_W;
  localparam int MID_W = OFS_W - LOW_W;

  logic [5:0] strobes;
  assign strobes = {jump_stb, call_stb, ret_stb, movpc_stb, addpc_stb, tbl_stb};

  // Decoder contract: one command at a time
  p_onehot_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_ev |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));

  p_cmd_beats_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && (strobes != '0)) |-> !seq_ev);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ev |=> $stable(pc_o));

  p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    jump_stb |=> pc_o == {$past(page_sel), $past(imm_target)});

  p_call_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && $past(push_ev)) |=> pc_o == PC_W'($past(pc_o, 2) + PC_W'(1)));

  p_mov_r7: assert property (@(posedge clk) disable iff (!rst_n)
    movpc_stb |=> pc_o == {$past(page_sel), {MID_W{1'b0}}, $past(acc_val)});

  p_tbl_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_stb |=> pc_o[PC_W-1:LOW_W] == $past(pc_o[PC_W-1:LOW_W]));

endmodule

bind paged_pc_seq paged_pc_seq_chk #(
  .PAGE_W(PAGE_W), .OFS_W(OFS_W), .LOW_W(LOW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inc_en     (inc_en),
  .jump_stb   (jump_stb),
  .call_stb   (call_stb),
  .ret_stb    (ret_stb),
  .movpc_stb  (movpc_stb),
  .addpc_stb  (addpc_stb),
  .tbl_stb    (tbl_stb),
  .imm_target (imm_target),
  .acc_val    (acc_val),
  .page_sel   (page_sel),
  .pc_o       (pc_o),
  .push_ev    (push_ev),
  .pop_ev     (pop_ev),
  .seq_ev     (seq_ev),
  .hold_ev    (hold_ev)
);

// File: tb/paged_pc_seq_tb.sv
`timescale 1ns/1ps
module paged_pc_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_en = 1'b0;
  logic        jump_stb = 1'b0, call_stb = 1'b0, ret_stb = 1'b0;
  logic        movpc_stb = 1'b0, addpc_stb = 1'b0, tbl_stb = 1'b0;
  logic [9:0]  imm_target = '0;
  logic [7:0]  acc_val = '0;
  logic [3:0]  page_sel = '0;
  logic [13:0] pc_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  paged_pc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .inc_en(inc_en),
    .jump_stb(jump_stb), .call_stb(call_stb), .ret_stb(ret_stb),
    .movpc_stb(movpc_stb), .addpc_stb(addpc_stb), .tbl_stb(tbl_stb),
    .imm_target(imm_target), .acc_val(acc_val), .page_sel(page_sel),
    .pc_o(pc_o)
  );

  task automatic chk(input string req, input logic [13:0] got,
                     input logic [13:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Inputs change at the falling edge; results are read one falling edge later
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_cmds();
    jump_stb = 0; call_stb = 0; ret_stb = 0;
    movpc_stb = 0; addpc_stb = 0; tbl_stb = 0;
  endtask

  task automatic do_reset();
    clear_cmds();
    inc_en = 0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic jmp(input logic [3:0] pg, input logic [9:0] imm);
    page_sel = pg; imm_target = imm; jump_stb = 1;
    tick(); clear_cmds();
  endtask

  task automatic call(input logic [3:0] pg, input logic [9:0] imm);
    page_sel = pg; imm_target = imm; call_stb = 1;
    tick(); clear_cmds();
  endtask

  task automatic ret();
    ret_stb = 1;
    tick(); clear_cmds();
  endtask

  function automatic logic [13:0] tgt(input logic [3:0] pg,
                                      input logic [9:0] imm);
    return (14'(pg) << 10) | 14'(imm);
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 reset address", pc_o, 14'h0000);
  endtask

  task automatic t_sequential();
    inc_en = 1;
    repeat (5) tick();
    chk("R2 five steps", pc_o, 14'h0005);
    inc_en = 0;
    jmp(4'hF, 10'h3FF);
    chk("R4 last address", pc_o, 14'h3FFF);
    inc_en = 1; tick(); inc_en = 0;
    chk("R2 wrap to zero", pc_o, 14'h0000);
  endtask

  task automatic t_hold();
    jmp(4'h2, 10'h077);
    repeat (3) tick();
    chk("R3 hold without enable", pc_o, 14'h0877);
  endtask

  task automatic t_jump_collide();
    inc_en = 1;
    jmp(4'h5, 10'h123);
    inc_en = 0;
    chk("R4 jump with inc_en high (R2 precedence)", pc_o, 14'h1523);
  endtask

  task automatic t_move();
    page_sel = 4'h2; acc_val = 8'hAB; movpc_stb = 1;
    tick(); clear_cmds();
    chk("R7 move accumulator", pc_o, 14'h08AB);
  endtask

  task automatic t_add();
    jmp(4'h3, 10'h3F0);
    chk("R4 setup add", pc_o, 14'h0FF0);
    page_sel = 4'h6; acc_val = 8'h20; addpc_stb = 1;
    tick(); clear_cmds();
    chk("R8 add wraps low byte, clears 9..8, reloads page", pc_o, 14'h1810);
  endtask

  task automatic t_table();
    jmp(4'h3, 10'h3F0);
    page_sel = 4'h9; acc_val = 8'h20; tbl_stb = 1; inc_en = 1;
    tick(); clear_cmds(); inc_en = 0;
    chk("R9 table keeps bits 13..8, page_sel ignored", pc_o, 14'h0F10);
  endtask

  task automatic t_call_ret();
    do_reset();
    jmp(4'h0, 10'h105);
    inc_en = 1;
    call(4'h1, 10'h020);
    chk("R5 call target with inc_en high", pc_o, 14'h0420);
    repeat (2) tick();
    inc_en = 0;
    chk("R2 advance inside subroutine", pc_o, 14'h0422);
    ret();
    chk("R6 return to call site plus one", pc_o, 14'h0106);
    call(4'h7, 10'h001);
    ret();
    chk("R6 back-to-back call and return", pc_o, 14'h0107);
  endtask

  task automatic t_nest8();
    logic [13:0] saved [8];
    logic [13:0] cur;
    do_reset();
    cur = 14'h0000;
    for (int i = 0; i < 8; i++) begin
      saved[i] = cur + 14'd1;
      call(4'(i + 1), 10'(i * 10 + 3));
      cur = tgt(4'(i + 1), 10'(i * 10 + 3));
      chk("R5 nested call target", pc_o, cur);
    end
    for (int i = 7; i >= 0; i--) begin
      ret();
      chk("R10 reverse order return", pc_o, saved[i]);
    end
  endtask

  task automatic t_overflow();
    logic [13:0] saved [9];
    logic [13:0] cur;
    do_reset();
    jmp(4'hA, 10'h200);
    cur = tgt(4'hA, 10'h200);
    for (int i = 0; i < 9; i++) begin
      saved[i] = cur + 14'd1;
      call(4'(i), 10'(i * 7 + 1));
      cur = tgt(4'(i), 10'(i * 7 + 1));
    end
    for (int i = 8; i >= 1; i--) begin
      ret();
      chk("R11 overflow return order", pc_o, saved[i]);
    end
    ret();
    chk("R11 ninth return sees overwriting entry", pc_o, saved[8]);
  endtask

  task automatic t_empty_pop();
    do_reset();
    jmp(4'h4, 10'h011);
    ret();
    chk("R12 pop on empty gives cleared slot", pc_o, 14'h0000);
    jmp(4'h0, 10'h055);
    call(4'hC, 10'h300);
    chk("R5 call after wrapped pop", pc_o, 14'h3300);
    ret();
    chk("R12 pairing after wrapped pop", pc_o, 14'h0056);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sequential();
    t_hold();
    t_jump_collide();
    t_move();
    t_add();
    t_table();
    t_call_ret();
    t_nest8();
    t_overflow();
    t_empty_pop();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule